// File: doc/BRIEF.md
# Energy-Budgeted Issue Selector

This block sits in the issue stage of an out-of-order core. Each cycle it looks at a small window of instructions that are waiting to issue and picks up to four of them for the execution ports. Two limits come from a power controller: a width cap that can lower the number of grants below the hardware maximum, and an energy budget for the cycle. Every window entry has an operation class, and a fixed table turns that class into an energy cost.

The scan is greedy and follows age. It starts at the entry named as oldest and walks upward through the window, wrapping around at the end. A ready entry is granted when a grant slot is still free under the width cap and its cost still fits inside the budget that remains. An entry that does not fit is skipped and stays in the window. The scan then goes on, so a younger and cheaper entry can still issue in the same cycle. The grants, their number and the energy they use all appear on registered outputs one clock after the inputs.

Top module: `energy_issue_select`

## Requirements
- R1: No more than four instructions are granted in one cycle, and `count_o` reports how many were granted.
- R2: The granted count never exceeds the width cap. A cap of 0 grants nothing. A cap above 4 acts as 4.
- R3: Class codes on `op_class_i` (3 bits per entry, entry e at bits 3e+2..3e) have these costs: 0 = ALU costs 1, 1 = shift costs 1, 2 = multiply costs 3, 3 = divide costs 5, 4 = load/store costs 2. The unused codes 5 to 7 cost 1.
- R4: `energy_o` equals the sum of the costs of the granted entries and never exceeds the budget given for that cycle. A budget of 0 grants nothing.
- R5: A ready entry whose cost would exceed the remaining budget is not granted, and the scan still goes on to younger entries, which may issue when they fit.
- R6: Age order starts at entry `oldest_i` and runs upward through the window indices, wrapping past the last index to 0. Grant slot 0 holds the oldest granted entry and slot 1 the next. Slots are filled from slot 0 with no gaps.
- R7: Only entries with both `valid_i` and `ready_i` set are granted. Each grant slot is zero or one-hot (bit e of slot s is `grant_o[s*8+e]`), and no entry appears in more than one slot.
- R8: Outputs are registered. They show the result for the inputs present at the previous rising edge, and they are all zero while `rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 8 | Entry holds an instruction |
| ready_i | input | 8 | Entry operands are ready |
| op_class_i | input | 24 | 3-bit operation class per entry |
| oldest_i | input | 3 | Index of the oldest window entry |
| width_lim_i | input | 3 | Runtime issue width cap |
| budget_i | input | 8 | Energy budget for this cycle |
| grant_o | output | 32 | Per-slot one-hot grant vectors, slot s at bits 8s+7..8s |
| count_o | output | 3 | Number of grants issued |
| energy_o | output | 8 | Total energy of the granted entries |

## Verification
The width cap and the energy budget can both limit the same scan. They can bind at the same entry, or one can stop grants while the other still has room. Directed vectors set this up: a budget that runs out exactly as the last allowed slot fills, and an expensive oldest entry that is skipped while cheaper younger entries fill the capped slots across the wrap point. A seeded random sweep with small budgets and caps from 0 to 7 then makes both limits bind together often. In every cycle the per-slot grants, the count and the energy are compared with a bench model of the greedy scan.

// File: rtl/eis_pkg.sv
package eis_pkg;
  localparam int CLASS_W = 3;
  localparam int COST_W  = 3;

  typedef enum logic [CLASS_W-1:0] {
    OP_ALU   = 3'd0,
    OP_SHIFT = 3'd1,
    OP_MUL   = 3'd2,
    OP_DIV   = 3'd3,
    OP_MEM   = 3'd4
  } op_class_e;

  // R3: energy per class; unused codes are charged like ALU work
  function automatic logic [COST_W-1:0] class_cost(input logic [CLASS_W-1:0] c);
    case (c)
      OP_ALU, OP_SHIFT: return COST_W'(1);
      OP_MUL:           return COST_W'(3);
      OP_DIV:           return COST_W'(5);
      OP_MEM:           return COST_W'(2);
      default:          return COST_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/eis_cost_map.sv
module eis_cost_map
  import eis_pkg::*;
#(
  parameter int WIN_DEPTH = 8
) (
  input  logic [WIN_DEPTH*CLASS_W-1:0] class_i,
  output logic [COST_W-1:0]            cost_o [WIN_DEPTH]
);
  for (genvar e = 0; e < WIN_DEPTH; e++) begin : g_entry
    assign cost_o[e] = class_cost(class_i[e*CLASS_W +: CLASS_W]);
  end
endmodule

// File: rtl/eis_age_order.sv
module eis_age_order
  import eis_pkg::*;
#(
  parameter int WIN_DEPTH = 8,
  parameter int IDX_W     = 3
) (
  input  logic [WIN_DEPTH-1:0] req_i,
  input  logic [COST_W-1:0]    cost_i    [WIN_DEPTH],
  input  logic [IDX_W-1:0]     oldest_i,
  output logic                 ord_req_o [WIN_DEPTH],
  output logic [COST_W-1:0]    ord_cost_o[WIN_DEPTH],
  output logic [IDX_W-1:0]     ord_idx_o [WIN_DEPTH]
);
  localparam logic [IDX_W:0] WIN_L = (IDX_W+1)'(WIN_DEPTH);

  // position k in age order maps to entry (oldest + k) mod depth
  for (genvar k = 0; k < WIN_DEPTH; k++) begin : g_pos
    logic [IDX_W:0]   raw;
    logic [IDX_W:0]   wrapped;
    logic [IDX_W-1:0] idx;
    assign raw     = {1'b0, oldest_i} + (IDX_W+1)'(k);
    assign wrapped = (raw >= WIN_L) ? (raw - WIN_L) : raw;
    assign idx     = wrapped[IDX_W-1:0];
    assign ord_req_o[k]  = req_i[idx];
    assign ord_cost_o[k] = cost_i[idx];
    assign ord_idx_o[k]  = idx;
  end
endmodule

// File: rtl/eis_greedy_pick.sv
module eis_greedy_pick
  import eis_pkg::*;
#(
  parameter int WIN_DEPTH = 8,
  parameter int ISSUE_MAX = 4,
  parameter int BUDGET_W  = 8,
  parameter int IDX_W     = 3,
  parameter int CNT_W     = 3
) (
  input  logic                ord_req_i [WIN_DEPTH],
  input  logic [COST_W-1:0]   ord_cost_i[WIN_DEPTH],
  input  logic [IDX_W-1:0]    ord_idx_i [WIN_DEPTH],
  input  logic [CNT_W-1:0]    lim_i,
  input  logic [BUDGET_W-1:0] budget_i,
  output logic                slot_vld_o[ISSUE_MAX],
  output logic [IDX_W-1:0]    slot_idx_o[ISSUE_MAX],
  output logic [CNT_W-1:0]    count_o,
  output logic [BUDGET_W-1:0] spent_o
);
  always_comb begin
    logic [BUDGET_W:0]   trial;
    logic [CNT_W-1:0]    cnt;
    logic [BUDGET_W-1:0] spent;
    cnt   = '0;
    spent = '0;
    trial = '0;
    for (int s = 0; s < ISSUE_MAX; s++) begin
      slot_vld_o[s] = 1'b0;
      slot_idx_o[s] = '0;
    end
    // R5: an entry that does not fit is passed over and the scan goes on
    for (int k = 0; k < WIN_DEPTH; k++) begin
      trial = {1'b0, spent} + (BUDGET_W+1)'(ord_cost_i[k]);
      if (ord_req_i[k] && (cnt < lim_i) && (trial <= {1'b0, budget_i})) begin
        for (int s = 0; s < ISSUE_MAX; s++) begin
          if (CNT_W'(s) == cnt) begin
            slot_vld_o[s] = 1'b1;
            slot_idx_o[s] = ord_idx_i[k];
          end
        end
        cnt   = cnt + CNT_W'(1);
        spent = trial[BUDGET_W-1:0];
      end
    end
    count_o = cnt;
    spent_o = spent;
  end
endmodule

// File: rtl/energy_issue_select.sv
module energy_issue_select
  import eis_pkg::*;
#(
  parameter  int WIN_DEPTH = 8,
  parameter  int ISSUE_MAX = 4,
  parameter  int BUDGET_W  = 8,
  parameter  int WLIM_W    = 3,
  localparam int IDX_W     = $clog2(WIN_DEPTH),
  localparam int CNT_W     = $clog2(ISSUE_MAX + 1)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [WIN_DEPTH-1:0]           valid_i,
  input  logic [WIN_DEPTH-1:0]           ready_i,
  input  logic [WIN_DEPTH*CLASS_W-1:0]   op_class_i,
  input  logic [IDX_W-1:0]               oldest_i,
  input  logic [WLIM_W-1:0]              width_lim_i,
  input  logic [BUDGET_W-1:0]            budget_i,
  output logic [ISSUE_MAX*WIN_DEPTH-1:0] grant_o,
  output logic [CNT_W-1:0]               count_o,
  output logic [BUDGET_W-1:0]            energy_o
);
  localparam logic [WLIM_W-1:0] CAP_W = WLIM_W'(ISSUE_MAX);

  logic [COST_W-1:0]   cost     [WIN_DEPTH];
  logic                ord_req  [WIN_DEPTH];
  logic [COST_W-1:0]   ord_cost [WIN_DEPTH];
  logic [IDX_W-1:0]    ord_idx  [WIN_DEPTH];
  logic                slot_vld [ISSUE_MAX];
  logic [IDX_W-1:0]    slot_idx [ISSUE_MAX];
  logic [CNT_W-1:0]    pick_cnt;
  logic [BUDGET_W-1:0] pick_spent;
  logic [CNT_W-1:0]    eff_lim;
  logic [WIN_DEPTH-1:0] req;

  assign req = valid_i & ready_i;

  // R2: caps above the hardware width fall back to the hardware width
  assign eff_lim = (width_lim_i > CAP_W) ? CNT_W'(ISSUE_MAX) : CNT_W'(width_lim_i);

  eis_cost_map #(.WIN_DEPTH(WIN_DEPTH)) u_cost (
    .class_i (op_class_i),
    .cost_o  (cost)
  );

  eis_age_order #(.WIN_DEPTH(WIN_DEPTH), .IDX_W(IDX_W)) u_order (
    .req_i      (req),
    .cost_i     (cost),
    .oldest_i   (oldest_i),
    .ord_req_o  (ord_req),
    .ord_cost_o (ord_cost),
    .ord_idx_o  (ord_idx)
  );

  eis_greedy_pick #(
    .WIN_DEPTH(WIN_DEPTH), .ISSUE_MAX(ISSUE_MAX), .BUDGET_W(BUDGET_W),
    .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_pick (
    .ord_req_i  (ord_req),
    .ord_cost_i (ord_cost),
    .ord_idx_i  (ord_idx),
    .lim_i      (eff_lim),
    .budget_i   (budget_i),
    .slot_vld_o (slot_vld),
    .slot_idx_o (slot_idx),
    .count_o    (pick_cnt),
    .spent_o    (pick_spent)
  );

  // R8: registered outputs, cleared by synchronous reset
  always_ff @(posedge clk) begin
    if (rst) begin
      grant_o  <= '0;
      count_o  <= '0;
      energy_o <= '0;
    end else begin
      for (int s = 0; s < ISSUE_MAX; s++) begin
        for (int e = 0; e < WIN_DEPTH; e++) begin
          grant_o[s*WIN_DEPTH + e] <= slot_vld[s] && (slot_idx[s] == IDX_W'(e));
        end
      end
      count_o  <= pick_cnt;
      energy_o <= pick_spent;
    end
  end
endmodule

// File: rtl/eis_checker.sv
module eis_checker #(
  parameter int WIN_DEPTH = 8,
  parameter int ISSUE_MAX = 4,
  parameter int BUDGET_W  = 8,
  parameter int WLIM_W    = 3,
  parameter int CNT_W     = 3
) (
  input logic                           clk,
  input logic                           rst,
  input logic [WIN_DEPTH-1:0]           valid_i,
  input logic [WIN_DEPTH-1:0]           ready_i,
  input logic [WLIM_W-1:0]              width_lim_i,
  input logic [BUDGET_W-1:0]            budget_i,
  input logic [ISSUE_MAX*WIN_DEPTH-1:0] grant_o,
  input logic [CNT_W-1:0]               count_o,
  input logic [BUDGET_W-1:0]            energy_o
);
  logic [WIN_DEPTH-1:0] any_grant;
  logic [WLIM_W-1:0]    cap_now;

  assign cap_now = (width_lim_i > WLIM_W'(ISSUE_MAX)) ? WLIM_W'(ISSUE_MAX) : width_lim_i;

  always_comb begin
    any_grant = '0;
    for (int s = 0; s < ISSUE_MAX; s++) any_grant = any_grant | grant_o[s*WIN_DEPTH +: WIN_DEPTH];
  end

  p_issue_cap_r1: assert property (@(posedge clk) disable iff (rst)
    count_o <= CNT_W'(ISSUE_MAX));

  p_width_cap_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (WLIM_W'(count_o) <= $past(cap_now)));

  p_cost_floor_r3: assert property (@(posedge clk) disable iff (rst)
    energy_o >= BUDGET_W'(count_o));

  p_budget_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (energy_o <= $past(budget_i)));

  p_ready_only_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((any_grant & ~$past(valid_i & ready_i)) == '0));

  p_distinct_r7: assert property (@(posedge clk) disable iff (rst)
    $countones(any_grant) == int'(count_o));

  p_reset_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (count_o == '0 && energy_o == '0 && grant_o == '0));

  for (genvar s = 0; s < ISSUE_MAX; s++) begin : g_slot
    logic [WIN_DEPTH-1:0] slot_bits;
    assign slot_bits = grant_o[s*WIN_DEPTH +: WIN_DEPTH];
    p_onehot_r7: assert property (@(posedge clk) disable iff (rst)
      $onehot0(slot_bits));
    p_packed_r6: assert property (@(posedge clk) disable iff (rst)
      (slot_bits != '0) == (count_o > CNT_W'(s)));
  end
endmodule

bind energy_issue_select eis_checker #(
  .WIN_DEPTH(WIN_DEPTH), .ISSUE_MAX(ISSUE_MAX), .BUDGET_W(BUDGET_W),
  .WLIM_W(WLIM_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .valid_i(valid_i), .ready_i(ready_i),
  .width_lim_i(width_lim_i), .budget_i(budget_i),
  .grant_o(grant_o), .count_o(count_o), .energy_o(energy_o)
);

// File: tb/energy_issue_select_bench.sv
`timescale 1ns/1ps
module energy_issue_select_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  valid_i = '0;
  logic [7:0]  ready_i = '0;
  logic [23:0] op_class_i = '0;
  logic [2:0]  oldest_i = '0;
  logic [2:0]  width_lim_i = '0;
  logic [7:0]  budget_i = '0;
  logic [31:0] grant_o;
  logic [2:0]  count_o;
  logic [7:0]  energy_o;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] exp_g;
  int exp_c, exp_e;

  always #2.5 clk = ~clk;

  energy_issue_select u_energy_issue_select (
    .clk(clk), .rst(rst), .valid_i(valid_i), .ready_i(ready_i),
    .op_class_i(op_class_i), .oldest_i(oldest_i), .width_lim_i(width_lim_i),
    .budget_i(budget_i), .grant_o(grant_o), .count_o(count_o), .energy_o(energy_o)
  );

  function automatic int cost_of(input logic [2:0] c);
    case (c)
      3'd2: return 3;
      3'd3: return 5;
      3'd4: return 2;
      default: return 1;
    endcase
  endfunction

  task automatic model(input logic [7:0] v, input logic [7:0] r, input logic [23:0] cls,
                       input logic [2:0] old, input logic [2:0] wl, input logic [7:0] bud,
                       output logic [31:0] g, output int cnt, output int en);
    int lim;
    lim = (wl > 3'd4) ? 4 : int'(wl);
    g = '0; cnt = 0; en = 0;
    for (int k = 0; k < 8; k++) begin
      int idx;
      int c;
      idx = (int'(old) + k) % 8;
      c = cost_of(cls[idx*3 +: 3]);
      if (v[idx] && r[idx] && cnt < lim && en + c <= int'(bud)) begin
        g[cnt*8 + idx] = 1'b1;
        cnt++;
        en += c;
      end
    end
  endtask

  task automatic check(input string tag, input logic [31:0] g, input int c, input int e);
    n_checks++;
    if (grant_o !== g || int'(count_o) != c || int'(energy_o) != e) begin
      n_fail++;
      $display("FAIL %s: actual grant=%h count=%0d energy=%0d expected grant=%h count=%0d energy=%0d",
               tag, grant_o, count_o, energy_o, g, c, e);
    end
  endtask

  task automatic drive(input logic [7:0] v, input logic [7:0] r, input logic [23:0] cls,
                       input logic [2:0] old, input logic [2:0] wl, input logic [7:0] bud);
    valid_i = v; ready_i = r; op_class_i = cls;
    oldest_i = old; width_lim_i = wl; budget_i = bud;
    model(v, r, cls, old, wl, bud, exp_g, exp_c, exp_e);
  endtask

  task automatic run_case(input string tag, input logic [7:0] v, input logic [7:0] r,
                          input logic [23:0] cls, input logic [2:0] old,
                          input logic [2:0] wl, input logic [7:0] bud);
    drive(v, r, cls, old, wl, bud);
    @(negedge clk);
    check(tag, exp_g, exp_c, exp_e);
  endtask

  function automatic logic [23:0] all_class(input logic [2:0] c);
    logic [23:0] x;
    for (int e = 0; e < 8; e++) x[e*3 +: 3] = c;
    return x;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog: actual=still running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] prev_g;
    int prev_c, prev_e;
    void'($urandom(32'h5EED_0042));
    // R8: reset holds outputs at zero even with a busy window
    drive(8'hFF, 8'hFF, all_class(3'd0), 3'd0, 3'd4, 8'd50);
    repeat (3) @(negedge clk);
    check("R8 reset state", '0, 0, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 full width after reset", exp_g, exp_c, exp_e);

    // R2: width caps
    run_case("R2 cap zero grants nothing", 8'hFF, 8'hFF, all_class(3'd0), 3'd0, 3'd0, 8'd100);
    run_case("R2 cap 2 of 4", 8'hFF, 8'hFF, all_class(3'd0), 3'd0, 3'd2, 8'd100);
    run_case("R2 cap 7 clamps to 4", 8'hFF, 8'hFF, all_class(3'd0), 3'd0, 3'd7, 8'd100);
    check("R1 explicit four slots", {8'h08, 8'h04, 8'h02, 8'h01}, 4, 4);

    // R3: each class code alone at entry 0
    for (int c = 0; c < 8; c++) begin
      run_case("R3 class cost", 8'h01, 8'h01, {21'd0, 3'(c)}, 3'd0, 3'd4, 8'd255);
    end
    run_case("R3 divide costs 5", 8'h01, 8'h01, 24'd3, 3'd0, 3'd4, 8'd255);
    check("R3 divide explicit", 32'h0000_0001, 1, 5);

    // R4: budget limits
    run_case("R4 zero budget", 8'hFF, 8'hFF, all_class(3'd0), 3'd0, 3'd4, 8'd0);
    run_case("R4 budget exactly spent", 8'h0F, 8'h0F, {12'd0, 3'd4, 3'd2, 3'd0, 3'd3}, 3'd0, 3'd4, 8'd11);

    // R5: old divide skipped, younger ALUs still go; then divide fits after skip of second divide
    run_case("R5 skip old divide", 8'h0F, 8'h0F, {12'd0, 3'd0, 3'd0, 3'd0, 3'd3}, 3'd0, 3'd4, 8'd4);
    check("R5 explicit", {8'h00, 8'h08, 8'h04, 8'h02}, 3, 3);
    run_case("R5 second divide skipped", 8'h07, 8'h07, {15'd0, 3'd0, 3'd3, 3'd3}, 3'd0, 3'd4, 8'd6);
    check("R5 div then alu", {8'h00, 8'h00, 8'h04, 8'h01}, 2, 6);

    // R6: age order wraps from oldest index
    run_case("R6 wrap order", 8'hFF, 8'hFF, all_class(3'd0), 3'd6, 3'd4, 8'd100);
    check("R6 slots 6,7,0,1", {8'h02, 8'h01, 8'h80, 8'h40}, 4, 4);

    // R7: valid and ready both required
    run_case("R7 ready gating", 8'hF0, 8'h3C, all_class(3'd0), 3'd0, 3'd4, 8'd100);
    check("R7 only 4 and 5", {8'h00, 8'h00, 8'h20, 8'h10}, 2, 2);

    // both limits bind at once across the wrap
    run_case("R2 R4 cap and budget together", 8'hFF, 8'hFF,
             {3'd4, 3'd4, 3'd0, 3'd0, 3'd2, 3'd3, 3'd2, 3'd1}, 3'd5, 3'd3, 8'd4);

    // R8: output holds until the next edge
    prev_g = exp_g; prev_c = exp_c; prev_e = exp_e;
    drive(8'hFF, 8'hFF, all_class(3'd2), 3'd1, 3'd4, 8'd9);
    #1;
    check("R8 holds before edge", prev_g, prev_c, prev_e);
    @(negedge clk);
    check("R8 updates after edge", exp_g, exp_c, exp_e);

    // random sweep
    for (int i = 0; i < 400; i++) begin
      logic [23:0] cls;
      for (int e = 0; e < 8; e++) begin
        cls[e*3 +: 3] = ($urandom % 8 == 0) ? 3'($urandom % 8) : 3'($urandom % 5);
      end
      run_case("R1 R4 R5 R6 random", 8'($urandom), 8'($urandom), cls,
               3'($urandom % 8), 3'($urandom % 8), 8'($urandom % 24));
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule